// File: doc/BRIEF.md
# USB Device Pipe Prime and Completion Register Block

This block holds the software-visible state a USB device controller keeps for every pipe: whether a transfer has been primed and not yet taken by the transfer engine, whether a flush is pending, whether a pipe is ready with a transfer loaded, and whether a transfer has finished. It also records setup packets that arrive on endpoint 0, keeps a per-endpoint control word (stall, enable, type, data-toggle reset), holds the device address, and raises one interrupt line from a status register gated by an enable register.

Software reaches the block over a plain 32-bit register bus with byte addresses, a write strobe and a read strobe. The transfer engine sits on the other side. It sees a per-pipe prime request and answers with a one-cycle accept pulse. It sees a per-pipe flush request and answers with a flush-done pulse. It reports transfer completion and setup arrival as one-cycle pulses. Bus events (error, port change, bus reset, start of frame, suspend) arrive as one-cycle pulses as well.

Pipe numbering on the engine-side vectors: pipe p < NUM_EP is the receive pipe of endpoint p, and pipe NUM_EP+n is the transmit pipe of endpoint n. In the 32-bit pipe registers, receive endpoint n uses bit n and transmit endpoint n uses bit 16+n.

Top module: `usbd_pipe_regs`

## Requirements
- R1: After reset every register reads 0, and irq, prime_req, flush_req, dev_addr and all endpoint control outputs are 0.
- R2: A 1 written to a bit of the prime register (offset 0x14; receive endpoint n at bit n, transmit endpoint n at bit 16+n) raises that pipe's prime_req from the next cycle. The bit holds until prime_ack for that pipe and is 0 the cycle after the ack. Written 0 bits have no effect. The register reads back the pending bits.
- R3: A pipe's bit in the ready register (offset 0x1C, same bit map) becomes 1 when prime_ack arrives while that pipe's prime is pending. An ack with no pending prime is ignored. The bit clears on that pipe's xfer_done pulse.
- R4: A 1 written to a bit of the flush register (offset 0x18, same bit map) raises flush_req until flush_ack for that pipe, and that ack also clears the pipe's ready bit. Writing all ones flushes every pipe. Bits with no pipe read 0.
- R5: An xfer_done pulse sets the pipe's bit in the completion register (offset 0x20, same bit map). A 1 written to a bit clears it. When a pulse and a clearing write hit the same bit in the same cycle, the bit ends up set.
- R6: A setup_evt pulse sets bit 0 of the setup register (offset 0x10). Writing 1 to that bit clears it, and writing 0 leaves it unchanged.
- R7: The interrupt status register (offset 0x00) is write-one-to-clear. Its bits are set by these sources: bit 0 by any xfer_done or setup_evt, bit 1 by err_evt, bit 2 by port_evt, bit 6 by bus_reset_evt, bit 7 by sof_evt, bit 8 by suspend_evt. All other bits read 0.
- R8: The interrupt enable register (offset 0x04) stores only bits 0, 1, 2, 6, 7 and 8, so writing all ones reads back 0x1C7. irq is 1 exactly one cycle after some status bit and its enable bit are both 1.
- R9: The control word of endpoint n is at offset 0x40+4n. Bit 0 is receive stall, bits 3:2 the receive type (0 control, 1 isochronous, 2 bulk, 3 interrupt), and bit 7 receive enable. Bits 16, 19:18 and 23 are the transmit counterparts. These fields are read-write and drive the matching outputs.
- R10: Bits 6 and 22 of an endpoint control word are toggle-reset commands for receive and transmit. Writing 1 to one of them pulses tog_rst_rx or tog_rst_tx for one cycle after the write, and the bits always read 0.
- R11: The device address register (offset 0x08, bits 6:0) drives dev_addr. A bus_reset_evt pulse clears the device address, the setup register and the completion register.
- R12: bus_rdata shows the addressed register one cycle after bus_rd, and holds that value while bus_rd is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| prime_req | output | 2*NUM_EP | Per-pipe prime pending |
| prime_ack | input | 2*NUM_EP | Engine accepted prime (pulse) |
| flush_req | output | 2*NUM_EP | Per-pipe flush pending |
| flush_ack | input | 2*NUM_EP | Engine finished flush (pulse) |
| xfer_done | input | 2*NUM_EP | Transfer complete (pulse) |
| setup_evt | input | 1 | Setup packet on endpoint 0 (pulse) |
| err_evt | input | 1 | Bus error (pulse) |
| port_evt | input | 1 | Port change (pulse) |
| bus_reset_evt | input | 1 | Bus reset seen (pulse) |
| sof_evt | input | 1 | Start of frame (pulse) |
| suspend_evt | input | 1 | Suspend entered (pulse) |
| stall_rx | output | NUM_EP | Receive stall per endpoint |
| stall_tx | output | NUM_EP | Transmit stall per endpoint |
| en_rx | output | NUM_EP | Receive enable per endpoint |
| en_tx | output | NUM_EP | Transmit enable per endpoint |
| type_rx | output | 2*NUM_EP | Receive type, 2 bits per endpoint |
| type_tx | output | 2*NUM_EP | Transmit type, 2 bits per endpoint |
| tog_rst_rx | output | NUM_EP | Receive toggle-reset pulse |
| tog_rst_tx | output | NUM_EP | Transmit toggle-reset pulse |
| dev_addr | output | 7 | Device address |
| irq | output | 1 | Interrupt request |

## Verification
A write captured on a rising edge changes the register, and prime_req, flush_req, dev_addr and the endpoint outputs, on that same edge. An engine pulse changes the pipe state and the interrupt status on the edge that samples it, and irq follows one edge later. Read data appears on the edge that samples bus_rd. The bench drives every stimulus on a falling edge and samples on the next falling edge, so each result is checked in the half-cycle after the edge that made it. For irq it checks both the cycle where the line must still be low and the one where it must have risen. The bench sweeps every pipe through the prime, ready, completion and flush sequence, every interrupt source with its enable both on and off, and every endpoint control word.

// File: rtl/usbd_pipe_pkg.sv
package usbd_pipe_pkg;

  // register byte offsets
  localparam int OFS_INT_STS = 'h00;
  localparam int OFS_INT_EN  = 'h04;
  localparam int OFS_DADDR   = 'h08;
  localparam int OFS_SETUP   = 'h10;
  localparam int OFS_PRIME   = 'h14;
  localparam int OFS_FLUSH   = 'h18;
  localparam int OFS_READY   = 'h1C;
  localparam int OFS_DONE    = 'h20;
  localparam int OFS_EPCTL   = 'h40;

  // transmit pipes start at this bit in pipe registers
  localparam int TX_HALF = 16;
  localparam int DEV_AW  = 7;

  // interrupt status bit positions
  localparam int INT_XFER = 0;
  localparam int INT_ERR  = 1;
  localparam int INT_PORT = 2;
  localparam int INT_BRST = 6;
  localparam int INT_SOF  = 7;
  localparam int INT_SUSP = 8;
  localparam logic [31:0] INT_MASK = (32'h1 << INT_XFER) | (32'h1 << INT_ERR) |
                                     (32'h1 << INT_PORT) | (32'h1 << INT_BRST) |
                                     (32'h1 << INT_SOF)  | (32'h1 << INT_SUSP);

  // endpoint control word, receive half; transmit half is +TX_HALF
  localparam int EPC_STALL = 0;
  localparam int EPC_TYPE  = 2;
  localparam int EPC_TOG   = 6;
  localparam int EPC_EN    = 7;

  typedef enum logic [1:0] {
    EPK_CONTROL = 2'd0,
    EPK_ISO     = 2'd1,
    EPK_BULK    = 2'd2,
    EPK_INTR    = 2'd3
  } ep_kind_e;

  // bit position of pipe p in a 32-bit pipe register
  function automatic int pipe_bit(input int p, input int n_ep);
    return (p < n_ep) ? p : TX_HALF + p - n_ep;
  endfunction

endpackage

// File: rtl/usbd_pipe_slot.sv
module usbd_pipe_slot (
  input  logic clk,
  input  logic rst,
  input  logic set_prime,
  input  logic set_flush,
  input  logic clr_done,
  input  logic prime_ack,
  input  logic flush_ack,
  input  logic xfer_done,
  input  logic bus_rst,
  output logic prime_pend,
  output logic flush_pend,
  output logic ready,
  output logic done
);

  // software request wins over a same-cycle accept
  always_ff @(posedge clk) begin
    if (rst)            prime_pend <= 1'b0;
    else if (set_prime) prime_pend <= 1'b1;
    else if (prime_ack) prime_pend <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst)            flush_pend <= 1'b0;
    else if (set_flush) flush_pend <= 1'b1;
    else if (flush_ack) flush_pend <= 1'b0;
  end

  // flush beats acceptance; completion retires the pipe
  always_ff @(posedge clk) begin
    if (rst)                           ready <= 1'b0;
    else if (flush_ack && flush_pend)  ready <= 1'b0;
    else if (prime_ack && prime_pend)  ready <= 1'b1;
    else if (xfer_done)                ready <= 1'b0;
  end

  // bus reset dominates, then a new event beats the clearing write
  always_ff @(posedge clk) begin
    if (rst)            done <= 1'b0;
    else if (bus_rst)   done <= 1'b0;
    else if (xfer_done) done <= 1'b1;
    else if (clr_done)  done <= 1'b0;
  end

endmodule

// File: rtl/usbd_intr_unit.sv
module usbd_intr_unit
  import usbd_pipe_pkg::*;
#(
  parameter logic [31:0] MASK = INT_MASK
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [31:0] events,
  input  logic        sts_wr,
  input  logic        en_wr,
  input  logic [31:0] wdata,
  output logic [31:0] status,
  output logic [31:0] enable,
  output logic        irq
);

  logic [31:0] clr_bits;
  assign clr_bits = sts_wr ? wdata : 32'h0;

  always_ff @(posedge clk) begin
    if (rst) status <= 32'h0;
    else     status <= ((status & ~clr_bits) | events) & MASK;
  end

  always_ff @(posedge clk) begin
    if (rst)        enable <= 32'h0;
    else if (en_wr) enable <= wdata & MASK;
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |(status & enable);
  end

endmodule

// File: rtl/usbd_ep_ctl_word.sv
module usbd_ep_ctl_word
  import usbd_pipe_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [31:0] wdata,
  output logic [31:0] rd_word,
  output logic        stall_rx,
  output logic        stall_tx,
  output logic        en_rx,
  output logic        en_tx,
  output logic [1:0]  type_rx,
  output logic [1:0]  type_tx,
  output logic        tog_rx,
  output logic        tog_tx
);

  localparam logic [15:0] HALF_RW = (16'h1 << EPC_STALL) | (16'h3 << EPC_TYPE) |
                                    (16'h1 << EPC_EN);
  localparam logic [31:0] RW_MASK = {HALF_RW, HALF_RW};

  logic [31:0] word_q;

  always_ff @(posedge clk) begin
    if (rst)        word_q <= 32'h0;
    else if (wr_en) word_q <= wdata & RW_MASK;
  end

  // toggle-reset commands are one-cycle strobes, never stored
  always_ff @(posedge clk) begin
    if (rst) begin
      tog_rx <= 1'b0;
      tog_tx <= 1'b0;
    end else begin
      tog_rx <= wr_en & wdata[EPC_TOG];
      tog_tx <= wr_en & wdata[TX_HALF + EPC_TOG];
    end
  end

  assign rd_word  = word_q;
  assign stall_rx = word_q[EPC_STALL];
  assign stall_tx = word_q[TX_HALF + EPC_STALL];
  assign en_rx    = word_q[EPC_EN];
  assign en_tx    = word_q[TX_HALF + EPC_EN];
  assign type_rx  = word_q[EPC_TYPE +: 2];
  assign type_tx  = word_q[TX_HALF + EPC_TYPE +: 2];

endmodule

// File: rtl/usbd_pipe_regs.sv
module usbd_pipe_regs
  import usbd_pipe_pkg::*;
#(
  parameter int NUM_EP = 5,
  parameter int ADDR_W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  bus_wr,
  input  logic                  bus_rd,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [31:0]           bus_wdata,
  output logic [31:0]           bus_rdata,
  output logic [2*NUM_EP-1:0]   prime_req,
  input  logic [2*NUM_EP-1:0]   prime_ack,
  output logic [2*NUM_EP-1:0]   flush_req,
  input  logic [2*NUM_EP-1:0]   flush_ack,
  input  logic [2*NUM_EP-1:0]   xfer_done,
  input  logic                  setup_evt,
  input  logic                  err_evt,
  input  logic                  port_evt,
  input  logic                  bus_reset_evt,
  input  logic                  sof_evt,
  input  logic                  suspend_evt,
  output logic [NUM_EP-1:0]     stall_rx,
  output logic [NUM_EP-1:0]     stall_tx,
  output logic [NUM_EP-1:0]     en_rx,
  output logic [NUM_EP-1:0]     en_tx,
  output logic [2*NUM_EP-1:0]   type_rx,
  output logic [2*NUM_EP-1:0]   type_tx,
  output logic [NUM_EP-1:0]     tog_rst_rx,
  output logic [NUM_EP-1:0]     tog_rst_tx,
  output logic [DEV_AW-1:0]     dev_addr,
  output logic                  irq
);

  localparam int NPIPE = 2 * NUM_EP;

  // address decode
  logic hit_sts, hit_en, hit_daddr, hit_setup, hit_prime, hit_flush, hit_ready, hit_done;
  assign hit_sts   = (bus_addr == ADDR_W'(OFS_INT_STS));
  assign hit_en    = (bus_addr == ADDR_W'(OFS_INT_EN));
  assign hit_daddr = (bus_addr == ADDR_W'(OFS_DADDR));
  assign hit_setup = (bus_addr == ADDR_W'(OFS_SETUP));
  assign hit_prime = (bus_addr == ADDR_W'(OFS_PRIME));
  assign hit_flush = (bus_addr == ADDR_W'(OFS_FLUSH));
  assign hit_ready = (bus_addr == ADDR_W'(OFS_READY));
  assign hit_done  = (bus_addr == ADDR_W'(OFS_DONE));

  // per-pipe state
  logic [NPIPE-1:0] pipe_ready;
  logic [NPIPE-1:0] done_vec;

  for (genvar p = 0; p < NPIPE; p++) begin : g_pipe
    localparam int BP = pipe_bit(p, NUM_EP);
    usbd_pipe_slot u_slot (
      .clk        (clk),
      .rst        (rst),
      .set_prime  (bus_wr && hit_prime && bus_wdata[BP]),
      .set_flush  (bus_wr && hit_flush && bus_wdata[BP]),
      .clr_done   (bus_wr && hit_done  && bus_wdata[BP]),
      .prime_ack  (prime_ack[p]),
      .flush_ack  (flush_ack[p]),
      .xfer_done  (xfer_done[p]),
      .bus_rst    (bus_reset_evt),
      .prime_pend (prime_req[p]),
      .flush_pend (flush_req[p]),
      .ready      (pipe_ready[p]),
      .done       (done_vec[p])
    );
  end

  // scatter pipe vectors into the split 32-bit layout
  logic [31:0] img_prime, img_flush, img_ready, img_done;
  always_comb begin
    img_prime = 32'h0;
    img_flush = 32'h0;
    img_ready = 32'h0;
    img_done  = 32'h0;
    for (int p = 0; p < NPIPE; p++) begin
      img_prime[pipe_bit(p, NUM_EP)] = prime_req[p];
      img_flush[pipe_bit(p, NUM_EP)] = flush_req[p];
      img_ready[pipe_bit(p, NUM_EP)] = pipe_ready[p];
      img_done[pipe_bit(p, NUM_EP)]  = done_vec[p];
    end
  end

  // endpoint 0 setup flag
  logic setup_bit;
  always_ff @(posedge clk) begin
    if (rst)                                    setup_bit <= 1'b0;
    else if (bus_reset_evt)                     setup_bit <= 1'b0;
    else if (setup_evt)                         setup_bit <= 1'b1;
    else if (bus_wr && hit_setup && bus_wdata[0]) setup_bit <= 1'b0;
  end

  // device address
  always_ff @(posedge clk) begin
    if (rst)                       dev_addr <= '0;
    else if (bus_reset_evt)        dev_addr <= '0;
    else if (bus_wr && hit_daddr)  dev_addr <= bus_wdata[DEV_AW-1:0];
  end

  // interrupt sources
  logic [31:0] int_events;
  always_comb begin
    int_events           = 32'h0;
    int_events[INT_XFER] = (|xfer_done) | setup_evt;
    int_events[INT_ERR]  = err_evt;
    int_events[INT_PORT] = port_evt;
    int_events[INT_BRST] = bus_reset_evt;
    int_events[INT_SOF]  = sof_evt;
    int_events[INT_SUSP] = suspend_evt;
  end

  logic [31:0] int_sts, int_en;

  usbd_intr_unit #(.MASK(INT_MASK)) u_intr (
    .clk    (clk),
    .rst    (rst),
    .events (int_events),
    .sts_wr (bus_wr && hit_sts),
    .en_wr  (bus_wr && hit_en),
    .wdata  (bus_wdata),
    .status (int_sts),
    .enable (int_en),
    .irq    (irq)
  );

  // endpoint control words
  logic [31:0] ep_word [NUM_EP];

  for (genvar n = 0; n < NUM_EP; n++) begin : g_ep
    usbd_ep_ctl_word u_ep (
      .clk      (clk),
      .rst      (rst),
      .wr_en    (bus_wr && (bus_addr == ADDR_W'(OFS_EPCTL + 4 * n))),
      .wdata    (bus_wdata),
      .rd_word  (ep_word[n]),
      .stall_rx (stall_rx[n]),
      .stall_tx (stall_tx[n]),
      .en_rx    (en_rx[n]),
      .en_tx    (en_tx[n]),
      .type_rx  (type_rx[2*n +: 2]),
      .type_tx  (type_tx[2*n +: 2]),
      .tog_rx   (tog_rst_rx[n]),
      .tog_tx   (tog_rst_tx[n])
    );
  end

  // read path
  logic [31:0] rd_next;
  always_comb begin
    rd_next = 32'h0;
    if (hit_sts)        rd_next = int_sts;
    else if (hit_en)    rd_next = int_en;
    else if (hit_daddr) rd_next = {{(32-DEV_AW){1'b0}}, dev_addr};
    else if (hit_setup) rd_next = {31'h0, setup_bit};
    else if (hit_prime) rd_next = img_prime;
    else if (hit_flush) rd_next = img_flush;
    else if (hit_ready) rd_next = img_ready;
    else if (hit_done)  rd_next = img_done;
    else begin
      for (int i = 0; i < NUM_EP; i++) begin
        if (bus_addr == ADDR_W'(OFS_EPCTL + 4 * i)) rd_next = ep_word[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= 32'h0;
    else if (bus_rd) bus_rdata <= rd_next;
  end

endmodule

// File: rtl/usbd_pipe_regs_chk.sv
module usbd_pipe_regs_chk
  import usbd_pipe_pkg::*;
#(
  parameter int NUM_EP = 5
) (
  input logic                clk,
  input logic                rst,
  input logic [2*NUM_EP-1:0] prime_req,
  input logic [2*NUM_EP-1:0] prime_ack,
  input logic [2*NUM_EP-1:0] flush_req,
  input logic [2*NUM_EP-1:0] flush_ack,
  input logic [2*NUM_EP-1:0] pipe_ready,
  input logic [2*NUM_EP-1:0] done_vec,
  input logic                setup_bit,
  input logic [DEV_AW-1:0]   dev_addr,
  input logic                bus_reset_evt,
  input logic [31:0]         int_sts,
  input logic [31:0]         int_en,
  input logic                irq
);

  // R2
  prime_hold_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((($past(prime_req) & ~$past(prime_ack)) & ~prime_req) == '0));

  // R3
  ready_rise_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (((pipe_ready & ~$past(pipe_ready)) & ~($past(prime_ack) & $past(prime_req))) == '0));

  // R4
  flush_drop_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(flush_req & flush_ack) & pipe_ready) == '0));

  // R8
  irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq == $past(|(int_sts & int_en))));

  // R11
  bus_reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    bus_reset_evt |=> (done_vec == '0 && !setup_bit && dev_addr == '0));

endmodule

bind usbd_pipe_regs usbd_pipe_regs_chk #(.NUM_EP(NUM_EP)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .prime_req     (prime_req),
  .prime_ack     (prime_ack),
  .flush_req     (flush_req),
  .flush_ack     (flush_ack),
  .pipe_ready    (pipe_ready),
  .done_vec      (done_vec),
  .setup_bit     (setup_bit),
  .dev_addr      (dev_addr),
  .bus_reset_evt (bus_reset_evt),
  .int_sts       (int_sts),
  .int_en        (int_en),
  .irq           (irq)
);

// File: tb/tb_usbd_pipe_regs.sv
module tb_usbd_pipe_regs;

  localparam int NE = 5;
  localparam int NP = 2 * NE;
  localparam int WD_CYCLES = 50000;

  localparam logic [7:0] A_STS = 8'h00, A_EN = 8'h04, A_DADDR = 8'h08, A_SETUP = 8'h10;
  localparam logic [7:0] A_PRIME = 8'h14, A_FLUSH = 8'h18, A_READY = 8'h1C, A_DONE = 8'h20;
  localparam logic [7:0] A_EPC = 8'h40;
  localparam logic [31:0] ALL_PIPES = 32'h001F001F;
  localparam logic [31:0] EPC_RW = 32'h008D008D;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_addr = 8'h0;
  logic [31:0] bus_wdata = 32'h0;
  logic [31:0] bus_rdata;
  logic [NP-1:0] prime_req, flush_req;
  logic [NP-1:0] prime_ack = '0, flush_ack = '0, xfer_done = '0;
  logic setup_evt = 0, err_evt = 0, port_evt = 0, bus_reset_evt = 0, sof_evt = 0, suspend_evt = 0;
  logic [NE-1:0] stall_rx, stall_tx, en_rx, en_tx, tog_rst_rx, tog_rst_tx;
  logic [NP-1:0] type_rx, type_tx;
  logic [6:0] dev_addr;
  logic irq;

  usbd_pipe_regs #(.NUM_EP(NE), .ADDR_W(8)) dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .prime_req(prime_req), .prime_ack(prime_ack), .flush_req(flush_req), .flush_ack(flush_ack),
    .xfer_done(xfer_done), .setup_evt(setup_evt), .err_evt(err_evt), .port_evt(port_evt),
    .bus_reset_evt(bus_reset_evt), .sof_evt(sof_evt), .suspend_evt(suspend_evt),
    .stall_rx(stall_rx), .stall_tx(stall_tx), .en_rx(en_rx), .en_tx(en_tx),
    .type_rx(type_rx), .type_tx(type_tx), .tog_rst_rx(tog_rst_rx), .tog_rst_tx(tog_rst_tx),
    .dev_addr(dev_addr), .irq(irq)
  );

  always #10 clk = ~clk;

  int vectors = 0;
  int fails = 0;
  bit finished = 0;

  function automatic logic [31:0] map_bit(input int p);
    return (p < NE) ? (32'h1 << p) : (32'h1 << (16 + p - NE));
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // all tasks start and end on a falling edge
  task automatic tick();
    @(negedge clk);
  endtask

  task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [7:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic expect_reg(input string tag, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] d;
    reg_read(a, d);
    chk(tag, d, exp);
  endtask

  initial begin : watchdog
    repeat (WD_CYCLES) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: got %0d cycles expected completion", WD_CYCLES);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] d;
    logic [31:0] word;
    logic [NP-1:0] left;
    logic [31:0] left_img;

    repeat (3) tick();
    rst = 1'b0;
    tick();

    // R1 reset state
    expect_reg("R1 int status", A_STS, 32'h0);
    expect_reg("R1 int enable", A_EN, 32'h0);
    expect_reg("R1 dev addr", A_DADDR, 32'h0);
    expect_reg("R1 setup", A_SETUP, 32'h0);
    expect_reg("R1 prime", A_PRIME, 32'h0);
    expect_reg("R1 ready", A_READY, 32'h0);
    expect_reg("R1 done", A_DONE, 32'h0);
    for (int n = 0; n < NE; n++) expect_reg("R1 ep ctl", A_EPC + 8'(4 * n), 32'h0);
    chk("R1 outputs", {irq, 7'(dev_addr), 10'(prime_req), 10'(flush_req)}, 32'h0);
    chk("R1 ep outputs", {stall_rx, stall_tx, en_rx, en_tx, tog_rst_rx, tog_rst_tx}, 32'h0);

    // prime -> accept -> complete sweep over every pipe
    for (int p = 0; p < NP; p++) begin
      logic [31:0] m;
      logic [NP-1:0] pv;
      m = map_bit(p);
      pv = NP'(1) << p;
      reg_write(A_PRIME, m);
      chk("R2 prime_req set", 32'(prime_req), 32'(pv));
      reg_write(A_PRIME, 32'h0);
      tick();
      chk("R2 prime held, zero write ignored", 32'(prime_req), 32'(pv));
      expect_reg("R2 prime readback", A_PRIME, m);
      expect_reg("R12 read held", A_STS, 32'h0);
      tick();
      chk("R12 rdata stable", bus_rdata, 32'h0);
      prime_ack = pv; tick(); prime_ack = '0;
      chk("R2 prime_req cleared", 32'(prime_req), 32'h0);
      expect_reg("R3 ready set", A_READY, m);
      xfer_done = pv; tick(); xfer_done = '0;
      expect_reg("R3 ready cleared by completion", A_READY, 32'h0);
      expect_reg("R5 done set", A_DONE, m);
      expect_reg("R7 transaction bit", A_STS, 32'h1);
      reg_write(A_DONE, m);
      expect_reg("R5 done w1c", A_DONE, 32'h0);
      reg_write(A_STS, 32'h1);
      expect_reg("R7 status w1c", A_STS, 32'h0);
    end

    // R3 accept without a pending prime
    prime_ack = '1; tick(); prime_ack = '0;
    expect_reg("R3 stray ack ignored", A_READY, 32'h0);

    // R4 flush every pipe, then retire one at a time
    reg_write(A_PRIME, ALL_PIPES);
    chk("R2 all primed", 32'(prime_req), 32'(NP'('1)));
    prime_ack = '1; tick(); prime_ack = '0;
    expect_reg("R3 all ready", A_READY, ALL_PIPES);
    reg_write(A_FLUSH, 32'hFFFF_FFFF);
    chk("R4 flush all raised", 32'(flush_req), 32'(NP'('1)));
    expect_reg("R4 flush readback no extra bits", A_FLUSH, ALL_PIPES);
    left = '1;
    left_img = ALL_PIPES;
    for (int p = 0; p < NP; p++) begin
      flush_ack = NP'(1) << p; tick(); flush_ack = '0;
      left[p] = 1'b0;
      left_img = left_img & ~map_bit(p);
      chk("R4 flush self-clear", 32'(flush_req), 32'(left));
      expect_reg("R4 flush clears ready", A_READY, left_img);
    end

    // R5 completion pulse beats a same-cycle clear
    xfer_done = NP'(1); tick(); xfer_done = '0;
    xfer_done = NP'(1);
    reg_write(A_DONE, 32'h1);
    xfer_done = '0;
    expect_reg("R5 set wins over clear", A_DONE, 32'h1);
    reg_write(A_DONE, 32'h1);
    expect_reg("R5 cleared", A_DONE, 32'h0);

    // R6 setup flag
    setup_evt = 1'b1; tick(); setup_evt = 1'b0;
    expect_reg("R6 setup set", A_SETUP, 32'h1);
    reg_write(A_SETUP, 32'h0);
    expect_reg("R6 zero write ignored", A_SETUP, 32'h1);
    reg_write(A_SETUP, 32'h1);
    expect_reg("R6 setup w1c", A_SETUP, 32'h0);

    // R8 enable layout
    reg_write(A_EN, 32'hFFFF_FFFF);
    expect_reg("R8 enable mask", A_EN, 32'h0000_01C7);
    reg_write(A_EN, 32'h0);

    // R7/R8 every source, enable on and off
    for (int i = 0; i < 6; i++) begin
      int b;
      b = (i < 3) ? i : i + 3;
      for (int e = 0; e < 2; e++) begin
        reg_write(A_EN, (e != 0) ? (32'h1 << b) : 32'h0);
        reg_write(A_STS, 32'hFFFF_FFFF);
        reg_write(A_SETUP, 32'h1);
        tick();
        chk("R8 irq idle", 32'(irq), 32'h0);
        case (b)
          0: setup_evt = 1'b1;
          1: err_evt = 1'b1;
          2: port_evt = 1'b1;
          6: bus_reset_evt = 1'b1;
          7: sof_evt = 1'b1;
          default: suspend_evt = 1'b1;
        endcase
        tick();
        {setup_evt, err_evt, port_evt, bus_reset_evt, sof_evt, suspend_evt} = '0;
        chk("R8 irq one cycle behind status", 32'(irq), 32'h0);
        tick();
        chk("R8 irq gated by enable", 32'(irq), 32'(e));
        expect_reg("R7 source bit", A_STS, 32'h1 << b);
      end
    end
    reg_write(A_EN, 32'h0);
    reg_write(A_STS, 32'hFFFF_FFFF);

    // R9/R10 endpoint control words
    for (int n = 0; n < NE; n++) begin
      word = (32'(n % 4) << 2) | (32'((n + 1) % 4) << 18) | 32'h0040_0040;
      if (n % 2 == 1) word = word | 32'h1;
      else            word = word | 32'h0001_0000;
      if (n > 1)      word = word | 32'h0080_0000;
      else            word = word | 32'h0000_0080;
      reg_write(A_EPC + 8'(4 * n), word);
      chk("R10 rx toggle pulse", 32'(tog_rst_rx), 32'(NE'(1) << n));
      chk("R10 tx toggle pulse", 32'(tog_rst_tx), 32'(NE'(1) << n));
      tick();
      chk("R10 toggle pulse ends", 32'({tog_rst_rx, tog_rst_tx}), 32'h0);
      expect_reg("R10 toggle reads 0", A_EPC + 8'(4 * n), word & EPC_RW);
      chk("R9 stall outputs", {30'h0, stall_tx[n], stall_rx[n]}, {30'h0, word[16], word[0]});
      chk("R9 enable outputs", {30'h0, en_tx[n], en_rx[n]}, {30'h0, word[23], word[7]});
      chk("R9 type outputs", {28'h0, type_tx[2*n +: 2], type_rx[2*n +: 2]},
          {28'h0, word[19:18], word[3:2]});
    end
    reg_write(A_EPC, 32'hFFFF_FFFF);
    expect_reg("R9 ep word all ones", A_EPC, EPC_RW);

    // R11 device address and bus reset clears
    reg_write(A_DADDR, 32'hFFFF_FF55);
    expect_reg("R11 dev addr readback", A_DADDR, 32'h55);
    chk("R11 dev addr port", 32'(dev_addr), 32'h55);
    xfer_done = NP'(8); setup_evt = 1'b1; tick(); xfer_done = '0; setup_evt = 1'b0;
    expect_reg("R5 done before reset", A_DONE, 32'h8);
    bus_reset_evt = 1'b1; tick(); bus_reset_evt = 1'b0;
    chk("R11 dev addr cleared", 32'(dev_addr), 32'h0);
    expect_reg("R11 done cleared", A_DONE, 32'h0);
    expect_reg("R11 setup cleared", A_SETUP, 32'h0);
    reg_read(A_STS, d);
    chk("R7 bus reset status bit", d & 32'h40, 32'h40);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule